// File: doc/BRIEF.md
# Bus Handoff Arbiter

This block is the processor-side arbiter for a three-wire bus handoff: request, grant and acknowledge, all active low. External masters pull a shared request line low. The request line may be a wire-OR of several requesters, so more than one request can be present at once. The arbiter answers with a grant. A granted master waits for the acknowledge line to be free, then drives acknowledge low and becomes the owner. An internal `cpu_owns` output tells the processor core whether it may run bus cycles.

Grant is issued only on a processor cycle boundary, which is when `cpu_busy` is low. It is also issued at any time while the processor is halted or stopped on a fault, because no processor cycle is then in progress. The arbiter drops the grant a fixed number of clocks after acknowledge appears. If a request is still pending at that point, it raises the grant again after a second fixed delay, while the current owner still holds the bus. External logic can therefore pick the next master early. When acknowledge is released and no request remains, the processor takes the bus back.

Request and acknowledge are asynchronous to the clock and pass through a synchronizer of `SYNC_STAGES` flops. With the default of two, an input change first captured at clock edge 0 is acted on by the state machine at edge 2.

Top module: `bus_handoff_arbiter`

## Requirements
- R1: After reset, `bg_n` is 1 (no grant) and `cpu_owns` is 1, and both stay so while `br_n` is high.
- R2: When `br_n` goes low while the processor may yield, let edge 0 be the clock edge that first captures it. At edge 2, `bg_n` goes to 0 and `cpu_owns` goes to 0 together. `bg_n` = 0 and `cpu_owns` = 1 never hold at the same time.
- R3: While `cpu_busy` is 1, and `halt_req` and `fault_stop` are both 0, a pending request is not granted. The grant appears at the first clock edge that samples `cpu_busy` at 0.
- R4: While `halt_req` or `fault_stop` is 1, a pending request is granted with R2 timing even when `cpu_busy` is 1.
- R5: Let edge 0 be the edge that first captures `bgack_n` low while the bus is granted. `bg_n` returns to 1 at edge 2 + `NEG_DLY`, and `cpu_owns` stays 0.
- R6: If `br_n` is still low when `bg_n` returns to 1 under R5, `bg_n` goes to 0 again `REG_DLY` edges later, while `bgack_n` is still low.
- R7: Let edge 0 be the edge that first captures `bgack_n` high. With no request pending, `cpu_owns` becomes 1 at edge 2 and `bg_n` stays 1. With a request pending, `cpu_owns` stays 0 and `bg_n` is 0 from edge 2.
- R8: If `br_n` returns high while the grant is out and `bgack_n` was never asserted, let edge 0 be the edge that captures the withdrawal. At edge 2, `bg_n` goes to 1 and `cpu_owns` goes to 1.
- R9: If `bgack_n` falling and `br_n` rising reach the state machine in the same cycle, the acknowledge takes precedence. `cpu_owns` stays 0 and R5 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_n | input | 1 | Bus request, active low, asynchronous, may be wire-ORed |
| bgack_n | input | 1 | Grant acknowledge from the current external master, active low, asynchronous |
| cpu_busy | input | 1 | Processor bus cycle in progress; grant waits while high |
| halt_req | input | 1 | Processor halted by the external halt input; lifts the cycle-boundary wait |
| fault_stop | input | 1 | Processor stopped after a double bus fault; lifts the cycle-boundary wait |
| bg_n | output | 1 | Bus grant, active low, registered |
| cpu_owns | output | 1 | Processor owns the bus, registered |

## Verification
The collision of interest is the normal handshake: a new master drives acknowledge low and releases its request at the same instant, so both changes leave the synchronizers together. The state machine must then choose acknowledge over withdrawal. The bench changes both lines on the same clock, and judges the result by `cpu_owns` staying low in that cycle and by the grant dropping only after the negation delay. A second overlap is tested by handing the bus from one requester to another on the shared request line. The owner's release arrives while a re-grant is already out, and the bench checks that the grant stays low without a gap through the handover.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [2:0] {
    ST_CPU     = 3'd0,
    ST_GRANT   = 3'd1,
    ST_ACKD    = 3'd2,
    ST_EXT     = 3'd3,
    ST_RDLY    = 3'd4,
    ST_REGRANT = 3'd5
  } arb_state_t;

  function automatic logic grant_out(arb_state_t s);
    return (s == ST_GRANT) || (s == ST_ACKD) || (s == ST_REGRANT);
  endfunction

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int          W      = 2,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {STAGES{RST[b]}};
      else        sh <= {sh[STAGES-2:0], d[b]};
    end
    assign q[b] = sh[STAGES-1];
  end

endmodule

// File: rtl/arb_timer.sv
module arb_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_TIMER_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done); // R5

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
#(
  parameter int NEG_DLY = 2,
  parameter int REG_DLY = 2,
  parameter int CW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_s,
  input  logic          ack_s,
  input  logic          cpu_busy,
  input  logic          halt_req,
  input  logic          fault_stop,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          bg_n,
  output logic          cpu_owns
);

  arb_state_t st, nxt;
  logic       may_yield;

  assign may_yield = !cpu_busy || halt_req || fault_stop;

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_CPU: begin
        if (br_s && may_yield) nxt = ST_GRANT;
      end
      ST_GRANT: begin
        if (ack_s) begin
          nxt      = ST_ACKD;
          tmr_load = 1'b1;
          tmr_val  = CW'(NEG_DLY - 1);
        end else if (!br_s) begin
          nxt = ST_CPU;
        end
      end
      ST_ACKD: begin
        if (!ack_s) begin
          nxt = br_s ? ST_GRANT : ST_CPU;
        end else if (tmr_done) begin
          if (br_s) begin
            nxt      = ST_RDLY;
            tmr_load = 1'b1;
            tmr_val  = CW'(REG_DLY - 1);
          end else begin
            nxt = ST_EXT;
          end
        end
      end
      ST_EXT: begin
        if (!ack_s) begin
          nxt = br_s ? ST_GRANT : ST_CPU;
        end else if (br_s) begin
          nxt      = ST_RDLY;
          tmr_load = 1'b1;
          tmr_val  = CW'(REG_DLY - 1);
        end
      end
      ST_RDLY: begin
        if (!ack_s)        nxt = br_s ? ST_GRANT : ST_CPU;
        else if (!br_s)    nxt = ST_EXT;
        else if (tmr_done) nxt = ST_REGRANT;
      end
      ST_REGRANT: begin
        if (!ack_s)     nxt = br_s ? ST_GRANT : ST_CPU;
        else if (!br_s) nxt = ST_EXT;
      end
      default: nxt = ST_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_CPU;
      bg_n     <= 1'b1;
      cpu_owns <= 1'b1;
    end else begin
      st       <= nxt;
      bg_n     <= !grant_out(nxt);
      cpu_owns <= (nxt == ST_CPU);
    end
  end

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_owns && !bg_n)); // R2

  AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bg_n) && $past(cpu_owns)) |-> $past(!cpu_busy || halt_req || fault_stop)); // R3

  AST_NEG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bg_n) |-> ($past(ack_s) || $past(!br_s))); // R5

  AST_REGRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bg_n) && !$past(cpu_owns)) |-> $past(br_s)); // R6

  AST_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_owns) |-> ($past(!br_s) && $past(!ack_s))); // R7

  AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st == ST_GRANT) && $past(ack_s)) |-> !cpu_owns); // R9

endmodule

// File: rtl/bus_handoff_arbiter.sv
module bus_handoff_arbiter #(
  parameter int NEG_DLY     = 2,
  parameter int REG_DLY     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic br_n,
  input  logic bgack_n,
  input  logic cpu_busy,
  input  logic halt_req,
  input  logic fault_stop,
  output logic bg_n,
  output logic cpu_owns
);

  localparam int MAXD = (NEG_DLY > REG_DLY) ? NEG_DLY : REG_DLY;
  localparam int CW   = (MAXD < 2) ? 1 : $clog2(MAXD);

  logic [1:0]    raw_n, syn_n;
  logic          br_s, ack_s;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;

  assign raw_n = {bgack_n, br_n};

  arb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_n),
    .q     (syn_n)
  );

  assign br_s  = !syn_n[0];
  assign ack_s = !syn_n[1];

  arb_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  arb_fsm #(.NEG_DLY(NEG_DLY), .REG_DLY(REG_DLY), .CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_s       (br_s),
    .ack_s      (ack_s),
    .cpu_busy   (cpu_busy),
    .halt_req   (halt_req),
    .fault_stop (fault_stop),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .bg_n       (bg_n),
    .cpu_owns   (cpu_owns)
  );

endmodule

// File: tb/bus_handoff_arbiter_bench.sv
`timescale 1ns/1ps
module bus_handoff_arbiter_bench;

  localparam int ND = 3;
  localparam int RD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_a_n = 1'b1, br_b_n = 1'b1, bgack_n = 1'b1;
  logic cpu_busy = 1'b0, halt_req = 1'b0, fault_stop = 1'b0;
  logic bg_n, cpu_owns;

  always #2 clk = ~clk;

  bus_handoff_arbiter #(.NEG_DLY(ND), .REG_DLY(RD), .SYNC_STAGES(2)) u_bus_handoff_arbiter (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_n       (br_a_n & br_b_n),
    .bgack_n    (bgack_n),
    .cpu_busy   (cpu_busy),
    .halt_req   (halt_req),
    .fault_stop (fault_stop),
    .bg_n       (bg_n),
    .cpu_owns   (cpu_owns)
  );

  typedef struct {
    int    cyc;
    logic  bg;
    logic  own;
    string tag;
  } exp_t;

  exp_t q[$];
  int edge_cnt = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= edge_cnt) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (e.cyc < edge_cnt) begin
        n_bad++;
        $display("FAIL %s edge %0d: expectation missed (actual edge %0d, expected edge %0d)",
                 e.tag, e.cyc, edge_cnt, e.cyc);
      end else if (bg_n !== e.bg || cpu_owns !== e.own) begin
        n_bad++;
        $display("FAIL %s edge %0d: bg_n=%b cpu_owns=%b, expected bg_n=%b cpu_owns=%b",
                 e.tag, e.cyc, bg_n, cpu_owns, e.bg, e.own);
      end
    end
  end

  task automatic expect_span(int a, int b, logic bg, logic own, string tag);
    for (int i = a; i <= b; i++) q.push_back('{edge_cnt + i, bg, own, tag});
  endtask

  task automatic tick(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run();
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      n_bad++;
      $display("FAIL %s edge %0d: never compared (actual none, expected bg_n=%b cpu_owns=%b)",
               e.tag, e.cyc, e.bg, e.own);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run hung (actual timeout, expected completion)");
      finished = 1'b1;
      finish_run();
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    expect_span(1, 4, 1'b1, 1'b1, "R1");
    tick(5);

    // R2 grant, R9 ack beats simultaneous withdrawal, R5 negation, R7 return
    br_a_n = 1'b0;
    expect_span(1, 2, 1'b1, 1'b1, "R2");
    expect_span(3, 3, 1'b0, 1'b0, "R2");
    tick(3);
    bgack_n = 1'b0; br_a_n = 1'b1;
    expect_span(1, 2, 1'b0, 1'b0, "R5");
    expect_span(3, 3, 1'b0, 1'b0, "R9");
    expect_span(4, 2 + ND, 1'b0, 1'b0, "R5");
    expect_span(3 + ND, 5 + ND, 1'b1, 1'b0, "R5");
    tick(5 + ND);
    bgack_n = 1'b1;
    expect_span(1, 2, 1'b1, 1'b0, "R7");
    expect_span(3, 4, 1'b1, 1'b1, "R7");
    tick(5);

    // R3 wait for cycle boundary, then R8 withdrawal
    cpu_busy = 1'b1;
    br_a_n = 1'b0;
    expect_span(1, 6, 1'b1, 1'b1, "R3");
    tick(6);
    cpu_busy = 1'b0;
    expect_span(1, 1, 1'b0, 1'b0, "R3");
    tick(2);
    br_a_n = 1'b1;
    expect_span(1, 2, 1'b0, 1'b0, "R8");
    expect_span(3, 4, 1'b1, 1'b1, "R8");
    tick(5);

    // R4 halt and fault stop lift the boundary wait
    cpu_busy = 1'b1; halt_req = 1'b1;
    br_a_n = 1'b0;
    expect_span(1, 2, 1'b1, 1'b1, "R4");
    expect_span(3, 3, 1'b0, 1'b0, "R4");
    tick(3);
    br_a_n = 1'b1; halt_req = 1'b0;
    expect_span(1, 2, 1'b0, 1'b0, "R4");
    expect_span(3, 4, 1'b1, 1'b1, "R4");
    tick(5);
    fault_stop = 1'b1;
    br_a_n = 1'b0;
    expect_span(1, 2, 1'b1, 1'b1, "R4");
    expect_span(3, 3, 1'b0, 1'b0, "R4");
    tick(3);
    br_a_n = 1'b1; fault_stop = 1'b0;
    expect_span(1, 2, 1'b0, 1'b0, "R4");
    expect_span(3, 4, 1'b1, 1'b1, "R4");
    tick(5);
    cpu_busy = 1'b0;
    tick(2);

    // R6 early re-grant with a second requester on the shared line
    br_a_n = 1'b0;
    expect_span(1, 2, 1'b1, 1'b1, "R2");
    expect_span(3, 3, 1'b0, 1'b0, "R2");
    tick(3);
    bgack_n = 1'b0; br_a_n = 1'b1; br_b_n = 1'b0;
    expect_span(1, 2 + ND, 1'b0, 1'b0, "R6");
    expect_span(3 + ND, 2 + ND + RD, 1'b1, 1'b0, "R6");
    expect_span(3 + ND + RD, 4 + ND + RD, 1'b0, 1'b0, "R6");
    tick(4 + ND + RD);
    bgack_n = 1'b1;
    expect_span(1, 4, 1'b0, 1'b0, "R7");
    tick(4);
    bgack_n = 1'b0; br_b_n = 1'b1;
    expect_span(1, 2 + ND, 1'b0, 1'b0, "R5");
    expect_span(3 + ND, 4 + ND, 1'b1, 1'b0, "R5");
    tick(4 + ND);
    bgack_n = 1'b1;
    expect_span(1, 2, 1'b1, 1'b0, "R7");
    expect_span(3, 5, 1'b1, 1'b1, "R7");
    tick(7);

    if (!finished) begin
      finished = 1'b1;
      finish_run();
    end
  end

endmodule